// File: doc/BRIEF.md
# Digital audio port crossbar multiplexer

This block is the routing fabric between seven synchronous serial audio ports. Each port carries two data pins plus a transmit bit clock, transmit frame sync, receive bit clock and receive frame sync. Software gives each port two configuration words over a small register bus. The fabric then decides several things for that port:

- which other port feeds its receive data;
- whether each clock and frame-sync pin is driven by the fabric or left as an input;
- which port, and which side (receive or transmit) of that port, supplies every driven clock and frame sync;
- whether its receive and transmit sections share one clock pair;
- whether its two data pins are swapped.

Two network modes merge several ports' data onto one receiver. In the internal network mode, a per-port mask selects the data lines that are ANDed together. In the bus network mode, every other port that is also in bus network mode takes part in the AND, like an open-drain shared line. All routing is combinational from the stored configuration. Only the register bus is clocked.

Top module: `audio_port_xbar`

## Requirements
- R1: Port p uses two words. The control word is at address 2p and the data word at address 2p+1. A write lands on the rising edge on which cfg_wr is sampled high. A read returns the word on cfg_rdata one cycle after cfg_rd is sampled, and cfg_rdata holds that value until the next read. Bits that are not implemented read 0. The control word implements mask 0x9F1F1F1F and the data word implements mask 0x00007F77.
- R2: After reset, each control word reads 0x80000000 (shared-clock mode on) and each data word reads 0. All clock and frame-sync output enables are 0, pin_a_oe is 0 and pin_b_oe is 1 for every port.
- R3: The control word holds four 5-bit selectors at bit offsets 0 (transmit clock), 8 (transmit frame sync), 16 (receive clock) and 24 (receive frame sync). In each selector, bits [2:0] are the source port, bit 3 picks the source's receive-side signal when 1 (transmit-side when 0), and bit 4 is the direction. The output enable of each of the four signals equals its direction bit.
- R4: With control bit 31 clear, each driven clock or frame sync equals the pad input of its selected source port and side. A transmit-clock selector draws from the tclk_in/rclk_in pair, and a frame-sync selector draws from the tfs_in/rfs_in pair. A source value of 7 drives 0.
- R5: With control bit 31 set, the receive clock output follows the transmit-clock selector and the receive frame-sync output follows the transmit frame-sync selector. Their output enables still follow their own direction bits.
- R6: Data word bits [5:4] are the mode: 0 normal, 1 internal network, 2 bus network, 3 behaves as normal. In normal mode the port's receive data equals the transmit data of the port in data word bits [2:0]. A value of 7 gives 1.
- R7: In internal network mode, the receive data is the AND of the transmit data of every port j whose mask bit (data word bit 8+j) is 0. A mask of all ones gives 1.
- R8: In bus network mode, the receive data is the AND of the transmit data of every other port also in bus network mode. If no such port exists, it is 1.
- R9: Data word bit 6 is the swap bit. When it is 0, the port's transmit data is taken from pin_a_in and its receive data drives pin_b_out (pin_b_oe=1, pin_a_oe=0). When it is 1, transmit data comes from pin_b_in and receive data drives pin_a_out (pin_a_oe=1, pin_b_oe=0).
- R10: Writing a data word with bit 31 set returns both words of that port to their reset values, whatever the other bits hold. No other port's words change on any write.
- R11: Addresses 14 and 15 belong to no port. Writes to them change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Word address, 2*port + word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid one cycle after cfg_rd |
| tclk_in | input | 7 | Transmit bit clock pad inputs |
| tclk_out | output | 7 | Routed transmit bit clocks |
| tclk_oe | output | 7 | Transmit bit clock drive enables |
| tfs_in | input | 7 | Transmit frame sync pad inputs |
| tfs_out | output | 7 | Routed transmit frame syncs |
| tfs_oe | output | 7 | Transmit frame sync drive enables |
| rclk_in | input | 7 | Receive bit clock pad inputs |
| rclk_out | output | 7 | Routed receive bit clocks |
| rclk_oe | output | 7 | Receive bit clock drive enables |
| rfs_in | input | 7 | Receive frame sync pad inputs |
| rfs_out | output | 7 | Routed receive frame syncs |
| rfs_oe | output | 7 | Receive frame sync drive enables |
| pin_a_in | input | 7 | Data pin A pad inputs |
| pin_a_out | output | 7 | Data pin A drive values |
| pin_a_oe | output | 7 | Data pin A drive enables |
| pin_b_in | input | 7 | Data pin B pad inputs |
| pin_b_out | output | 7 | Data pin B drive values |
| pin_b_oe | output | 7 | Data pin B drive enables |

## Verification
A configuration write takes effect at the rising edge that samples it. The bench drives writes from one falling edge and checks routing only from the next falling edge on, so that one register stage lies between. Routing from pad inputs to outputs has no register. The bench changes pad inputs away from any edge and samples one time unit later, with no clock in between. A read result is due one cycle after the strobe, so the bench raises cfg_rd at a falling edge and compares cfg_rdata at the following falling edge.

// File: rtl/apx_pkg.sv
// Package: shared field layout, reset values and decoded configuration
// types of the audio port crossbar. Assumes selector fields of 3 bits, so
// at most seven ports (value 7 means "no source").
package apx_pkg;

    localparam int REG_W  = 32;
    localparam int SEL_W  = 3;
    localparam int MASK_W = 7;
    localparam int EXT_W  = 2 ** SEL_W;

    localparam logic [REG_W-1:0] CTRL_RST  = 32'h8000_0000;
    localparam logic [REG_W-1:0] DATA_RST  = 32'h0000_0000;
    localparam logic [REG_W-1:0] CTRL_IMPL = 32'h9F1F_1F1F;
    localparam logic [REG_W-1:0] DATA_IMPL = 32'h0000_7F77;
    localparam int               CLR_BIT   = 31;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_INTNET = 2'd1,
        MODE_BUSNET = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic             from_rx;
        logic             drive;
    } sig_sel_t;

    typedef struct packed {
        sig_sel_t          tclk;
        sig_sel_t          tfs;
        sig_sel_t          rclk;
        sig_sel_t          rfs;
        logic              shared;
        logic [SEL_W-1:0]  rxd_src;
        mode_e             mode;
        logic              swap;
        logic [MASK_W-1:0] mask;
    } port_cfg_t;

    // Unpacks one 5-bit selector field starting at bit offset base.
    function automatic sig_sel_t unpack_sel(logic [REG_W-1:0] w, int base);
        sig_sel_t s;
        s.src     = w[base +: SEL_W];
        s.from_rx = w[base + 3];
        s.drive   = w[base + 4];
        return s;
    endfunction

    // Turns the two stored words of a port into its routing configuration.
    function automatic port_cfg_t decode(logic [REG_W-1:0] ctrl, logic [REG_W-1:0] data);
        port_cfg_t c;
        c.tclk    = unpack_sel(ctrl, 0);
        c.tfs     = unpack_sel(ctrl, 8);
        c.rclk    = unpack_sel(ctrl, 16);
        c.rfs     = unpack_sel(ctrl, 24);
        c.shared  = ctrl[31];
        c.rxd_src = data[2:0];
        c.mode    = mode_e'(data[5:4]);
        c.swap    = data[6];
        c.mask    = data[14:8];
        return c;
    endfunction

endpackage

// File: rtl/apx_cfg_regs.sv
// Register file: two words per port, written and read over a simple
// strobe bus. Assumes address = 2*port + word; addresses beyond the last
// port are dead. A data-word write with the clear bit set restores both
// words of that port to their reset values.
module apx_cfg_regs
    import apx_pkg::*;
#(
    parameter int NPORTS = 7,
    parameter int AW     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic                          cfg_rd,
    input  logic [AW-1:0]                 cfg_addr,
    input  logic [REG_W-1:0]              cfg_wdata,
    output logic [REG_W-1:0]              cfg_rdata,
    output logic [NPORTS-1:0][REG_W-1:0]  ctrl_q,
    output logic [NPORTS-1:0][REG_W-1:0]  data_q
);

    localparam int PW = AW - 1;

    logic [PW-1:0] addr_port;
    logic          addr_word;
    logic          addr_valid;

    assign addr_port  = cfg_addr[AW-1:1];
    assign addr_word  = cfg_addr[0];
    assign addr_valid = (int'(addr_port) < NPORTS);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic hit;
        assign hit = cfg_wr && (int'(addr_port) == p);

        // Holds the two words of port p; clear command resets both.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[p] <= CTRL_RST;
                data_q[p] <= DATA_RST;
            end else if (hit && addr_word && cfg_wdata[CLR_BIT]) begin
                ctrl_q[p] <= CTRL_RST;
                data_q[p] <= DATA_RST;
            end else if (hit && addr_word) begin
                data_q[p] <= cfg_wdata & DATA_IMPL;
            end else if (hit) begin
                ctrl_q[p] <= cfg_wdata & CTRL_IMPL;
            end
        end
    end

    logic [REG_W-1:0] rd_mux;

    // Selects the addressed word, or zero for a dead address.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (addr_valid && int'(addr_port) == p)
                rd_mux = addr_word ? data_q[p] : ctrl_q[p];
        end
    end

    // Captures read data one cycle after the strobe and holds it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_rd)
            cfg_rdata <= rd_mux;
    end

endmodule

// File: rtl/apx_clk_route.sv
// Clock and frame-sync router: for every port, picks the pad input of a
// source port (receive or transmit side) for each of the four timing
// signals. In shared-clock mode the receive pair follows the transmit
// selectors. Assumes pad inputs are the observed pin values.
module apx_clk_route
    import apx_pkg::*;
#(
    parameter int NPORTS = 7
) (
    input  port_cfg_t [NPORTS-1:0] cfg,
    input  logic [NPORTS-1:0]      tclk_in,
    input  logic [NPORTS-1:0]      tfs_in,
    input  logic [NPORTS-1:0]      rclk_in,
    input  logic [NPORTS-1:0]      rfs_in,
    output logic [NPORTS-1:0]      tclk_out,
    output logic [NPORTS-1:0]      tfs_out,
    output logic [NPORTS-1:0]      rclk_out,
    output logic [NPORTS-1:0]      rfs_out,
    output logic [NPORTS-1:0]      tclk_oe,
    output logic [NPORTS-1:0]      tfs_oe,
    output logic [NPORTS-1:0]      rclk_oe,
    output logic [NPORTS-1:0]      rfs_oe
);

    logic [EXT_W-1:0] tclk_x, tfs_x, rclk_x, rfs_x;

    // Pads the input vectors so an unused source index reads 0.
    always_comb begin
        tclk_x = '0;
        tfs_x  = '0;
        rclk_x = '0;
        rfs_x  = '0;
        tclk_x[NPORTS-1:0] = tclk_in;
        tfs_x[NPORTS-1:0]  = tfs_in;
        rclk_x[NPORTS-1:0] = rclk_in;
        rfs_x[NPORTS-1:0]  = rfs_in;
    end

    function automatic logic pick(sig_sel_t s, logic [EXT_W-1:0] txv, logic [EXT_W-1:0] rxv);
        return s.from_rx ? rxv[s.src] : txv[s.src];
    endfunction

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        sig_sel_t rclk_sel, rfs_sel;

        // Chooses the receive-side selectors according to shared-clock mode.
        always_comb begin
            rclk_sel = cfg[p].shared ? cfg[p].tclk : cfg[p].rclk;
            rfs_sel  = cfg[p].shared ? cfg[p].tfs  : cfg[p].rfs;
        end

        // Drives the routed values and the per-signal enables.
        always_comb begin
            tclk_out[p] = pick(cfg[p].tclk, tclk_x, rclk_x);
            tfs_out[p]  = pick(cfg[p].tfs,  tfs_x,  rfs_x);
            rclk_out[p] = pick(rclk_sel,    tclk_x, rclk_x);
            rfs_out[p]  = pick(rfs_sel,     tfs_x,  rfs_x);
            tclk_oe[p]  = cfg[p].tclk.drive;
            tfs_oe[p]   = cfg[p].tfs.drive;
            rclk_oe[p]  = cfg[p].rclk.drive;
            rfs_oe[p]   = cfg[p].rfs.drive;
        end
    end

endmodule

// File: rtl/apx_data_route.sv
// Data router: derives each port's transmit data from its pins (swap
// aware), builds its receive data by mode (direct source, masked AND or
// bus AND) and places it on the pin not used for transmit. An empty AND
// yields the idle level 1.
module apx_data_route
    import apx_pkg::*;
#(
    parameter int NPORTS = 7
) (
    input  port_cfg_t [NPORTS-1:0] cfg,
    input  logic [NPORTS-1:0]      pin_a_in,
    input  logic [NPORTS-1:0]      pin_b_in,
    output logic [NPORTS-1:0]      pin_a_out,
    output logic [NPORTS-1:0]      pin_a_oe,
    output logic [NPORTS-1:0]      pin_b_out,
    output logic [NPORTS-1:0]      pin_b_oe
);

    logic [NPORTS-1:0] txd;
    logic [EXT_W-1:0]  txd_x;
    logic [NPORTS-1:0] rxd;
    logic [NPORTS-1:0] in_bus;

    // Collects transmit data from the pin each port uses for it.
    always_comb begin
        for (int j = 0; j < NPORTS; j++) begin
            txd[j]    = cfg[j].swap ? pin_b_in[j] : pin_a_in[j];
            in_bus[j] = (cfg[j].mode == MODE_BUSNET);
        end
        txd_x = '1;
        txd_x[NPORTS-1:0] = txd;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic net_and, bus_and, direct;

        // Reduces the masked and the bus-member data lines for port p.
        always_comb begin
            net_and = 1'b1;
            bus_and = 1'b1;
            for (int j = 0; j < NPORTS; j++) begin
                if (!cfg[p].mask[j])
                    net_and = net_and & txd[j];
                if (j != p && in_bus[j])
                    bus_and = bus_and & txd[j];
            end
            direct = txd_x[cfg[p].rxd_src];
        end

        // Picks the receive data by mode; reserved mode acts as normal.
        always_comb begin
            unique case (cfg[p].mode)
                MODE_INTNET: rxd[p] = net_and;
                MODE_BUSNET: rxd[p] = bus_and;
                default:     rxd[p] = direct;
            endcase
        end

        // Places receive data on the pin opposite the transmit pin.
        always_comb begin
            pin_a_out[p] = rxd[p];
            pin_b_out[p] = rxd[p];
            pin_a_oe[p]  = cfg[p].swap;
            pin_b_oe[p]  = !cfg[p].swap;
        end
    end

endmodule

// File: rtl/audio_port_xbar.sv
// Top of the audio port crossbar: register file plus combinational
// clock/frame-sync and data routers. Assumes NPORTS <= 7 (3-bit source
// fields) and pads/tristate buffers outside the block.
module audio_port_xbar
    import apx_pkg::*;
#(
    parameter int NPORTS = 7,
    localparam int AW    = $clog2(2 * NPORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic [NPORTS-1:0]    tclk_in,
    output logic [NPORTS-1:0]    tclk_out,
    output logic [NPORTS-1:0]    tclk_oe,
    input  logic [NPORTS-1:0]    tfs_in,
    output logic [NPORTS-1:0]    tfs_out,
    output logic [NPORTS-1:0]    tfs_oe,
    input  logic [NPORTS-1:0]    rclk_in,
    output logic [NPORTS-1:0]    rclk_out,
    output logic [NPORTS-1:0]    rclk_oe,
    input  logic [NPORTS-1:0]    rfs_in,
    output logic [NPORTS-1:0]    rfs_out,
    output logic [NPORTS-1:0]    rfs_oe,
    input  logic [NPORTS-1:0]    pin_a_in,
    output logic [NPORTS-1:0]    pin_a_out,
    output logic [NPORTS-1:0]    pin_a_oe,
    input  logic [NPORTS-1:0]    pin_b_in,
    output logic [NPORTS-1:0]    pin_b_out,
    output logic [NPORTS-1:0]    pin_b_oe
);

    logic [NPORTS-1:0][REG_W-1:0] ctrl_q;
    logic [NPORTS-1:0][REG_W-1:0] data_q;
    port_cfg_t [NPORTS-1:0]       cfg;

    apx_cfg_regs #(.NPORTS(NPORTS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctrl_q    (ctrl_q),
        .data_q    (data_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_dec
        // Decodes the stored words of port p into routing fields.
        always_comb cfg[p] = decode(ctrl_q[p], data_q[p]);
    end

    apx_clk_route #(.NPORTS(NPORTS)) u_clk (
        .cfg      (cfg),
        .tclk_in  (tclk_in),
        .tfs_in   (tfs_in),
        .rclk_in  (rclk_in),
        .rfs_in   (rfs_in),
        .tclk_out (tclk_out),
        .tfs_out  (tfs_out),
        .rclk_out (rclk_out),
        .rfs_out  (rfs_out),
        .tclk_oe  (tclk_oe),
        .tfs_oe   (tfs_oe),
        .rclk_oe  (rclk_oe),
        .rfs_oe   (rfs_oe)
    );

    apx_data_route #(.NPORTS(NPORTS)) u_data (
        .cfg       (cfg),
        .pin_a_in  (pin_a_in),
        .pin_b_in  (pin_b_in),
        .pin_a_out (pin_a_out),
        .pin_a_oe  (pin_a_oe),
        .pin_b_out (pin_b_out),
        .pin_b_oe  (pin_b_oe)
    );

endmodule

// File: rtl/apx_checker.sv
// Checker for the audio port crossbar, bound into the top. Watches the
// register bus, the stored words and the routed outputs.
module apx_checker
    import apx_pkg::*;
#(
    parameter int NPORTS = 7,
    parameter int AW     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_wr,
    input logic                         cfg_rd,
    input logic [AW-1:0]                cfg_addr,
    input logic [REG_W-1:0]             cfg_wdata,
    input logic [REG_W-1:0]             cfg_rdata,
    input logic [NPORTS-1:0][REG_W-1:0] ctrl_q,
    input logic [NPORTS-1:0][REG_W-1:0] data_q,
    input port_cfg_t [NPORTS-1:0]       cfg,
    input logic [NPORTS-1:0]            tclk_out,
    input logic [NPORTS-1:0]            tclk_oe,
    input logic [NPORTS-1:0]            tfs_out,
    input logic [NPORTS-1:0]            tfs_oe,
    input logic [NPORTS-1:0]            rclk_out,
    input logic [NPORTS-1:0]            rclk_oe,
    input logic [NPORTS-1:0]            rfs_out,
    input logic [NPORTS-1:0]            rfs_oe,
    input logic [NPORTS-1:0]            pin_a_out,
    input logic [NPORTS-1:0]            pin_a_oe,
    input logic [NPORTS-1:0]            pin_b_out,
    input logic [NPORTS-1:0]            pin_b_oe
);

    p_dead_addr_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && (int'(cfg_addr[AW-1:1]) >= NPORTS) |=> cfg_rdata == '0);

    for (genvar q = 0; q < NPORTS; q++) begin : g_q
        p_port_isolation_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_wr && (int'(cfg_addr[AW-1:1]) != q) |=> $stable(ctrl_q[q]) && $stable(data_q[q]));

        p_clear_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_wr && (int'(cfg_addr) == 2 * q + 1) && cfg_wdata[CLR_BIT]
            |=> ctrl_q[q] == CTRL_RST && data_q[q] == DATA_RST);

        p_one_data_pin_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({pin_a_oe[q], pin_b_oe[q]}) == 1);

        p_shared_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[q].shared && tclk_oe[q] && rclk_oe[q] |-> rclk_out[q] == tclk_out[q]);

        p_shared_fsync_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[q].shared && tfs_oe[q] && rfs_oe[q] |-> rfs_out[q] == tfs_out[q]);

        p_empty_mask_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[q].mode == MODE_INTNET && (&cfg[q].mask[NPORTS-1:0])
            |-> (cfg[q].swap ? pin_a_out[q] : pin_b_out[q]) == 1'b1);

        p_reset_undriven_r2: assert property (@(posedge clk)
            !rst_n |=> !tclk_oe[q] && !tfs_oe[q] && !rclk_oe[q] && !rfs_oe[q] && pin_b_oe[q]);
    end

endmodule

bind audio_port_xbar apx_checker #(.NPORTS(NPORTS), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ctrl_q    (ctrl_q),
    .data_q    (data_q),
    .cfg       (cfg),
    .tclk_out  (tclk_out),
    .tclk_oe   (tclk_oe),
    .tfs_out   (tfs_out),
    .tfs_oe    (tfs_oe),
    .rclk_out  (rclk_out),
    .rclk_oe   (rclk_oe),
    .rfs_out   (rfs_out),
    .rfs_oe    (rfs_oe),
    .pin_a_out (pin_a_out),
    .pin_a_oe  (pin_a_oe),
    .pin_b_out (pin_b_out),
    .pin_b_oe  (pin_b_oe)
);

// File: tb/tb_audio_port_xbar.sv
module tb_audio_port_xbar;

    localparam int CLK_PERIOD = 10;
    localparam int N = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [N-1:0] tclk_in = '0, tfs_in = '0, rclk_in = '0, rfs_in = '0;
    logic [N-1:0] pin_a_in = '0, pin_b_in = '0;
    logic [N-1:0] tclk_out, tclk_oe, tfs_out, tfs_oe, rclk_out, rclk_oe, rfs_out, rfs_oe;
    logic [N-1:0] pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;

    int tests = 0;
    int errors = 0;

    audio_port_xbar #(.NPORTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tclk_in(tclk_in), .tclk_out(tclk_out), .tclk_oe(tclk_oe),
        .tfs_in(tfs_in), .tfs_out(tfs_out), .tfs_oe(tfs_oe),
        .rclk_in(rclk_in), .rclk_out(rclk_out), .rclk_oe(rclk_oe),
        .rfs_in(rfs_in), .rfs_out(rfs_out), .rfs_oe(rfs_oe),
        .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            errors++;
            $display("[TB] FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(int addr, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = 4'(addr);
        @(negedge clk);
        cfg_rd = 1'b0;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    function automatic logic [31:0] sel(int s, bit fr, bit dr);
        return 32'(s) | (32'(fr) << 3) | (32'(dr) << 4);
    endfunction

    function automatic logic [31:0] mk_data(int src, int mode, bit swp, int mask);
        return 32'(src) | (32'(mode) << 4) | (32'(swp) << 6) | (32'(mask) << 8);
    endfunction

    function automatic logic pick(int s, bit fr, logic [N-1:0] txv, logic [N-1:0] rxv);
        if (s >= N) return 1'b0;
        return fr ? rxv[s] : txv[s];
    endfunction

    function automatic logic [N-1:0] pat(int k, int salt);
        return 7'((k * 37 + salt * 23 + 11) ^ (k * 5));
    endfunction

    task automatic clear_all();
        for (int p = 0; p < N; p++) wr(2 * p + 1, 32'h8000_0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        tests++;
        errors++;
        $display("[TB] FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R2: reset values and undriven timing pins
        for (int p = 0; p < N; p++) begin
            rd(2 * p, 32'h8000_0000, "R2 ctrl reset");
            rd(2 * p + 1, 32'h0, "R2 data reset");
        end
        chk("R2 clock enables", {tclk_oe, tfs_oe, rclk_oe, rfs_oe}, 32'h0);
        chk("R2 pin a enable", 32'(pin_a_oe), 32'h0);
        chk("R2 pin b enable", 32'(pin_b_oe), 32'h7F);

        // R1: implemented-bit masks, read latency and hold
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'h7FFF_FFFF);
        rd(6, 32'h9F1F_1F1F, "R1 ctrl readback");
        rd(7, 32'h0000_7F77, "R1 data readback");
        @(negedge clk); #1;
        chk("R1 rdata hold", cfg_rdata, 32'h0000_7F77);

        // R10: clear command on port 3 leaves port 2 intact
        wr(4, 32'h1234_5678);
        wr(5, 32'h0000_1234);
        wr(7, 32'h8000_7F77);
        rd(6, 32'h8000_0000, "R10 cleared ctrl");
        rd(7, 32'h0, "R10 cleared data");
        rd(4, 32'h1234_5678 & 32'h9F1F_1F1F, "R10 neighbour ctrl");
        rd(5, 32'h0000_1234 & 32'h0000_7F77, "R10 neighbour data");
        clear_all();

        // R11: dead addresses
        wr(14, 32'hFFFF_FFFF);
        wr(15, 32'h0000_7F77);
        rd(14, 32'h0, "R11 dead read 14");
        rd(15, 32'h0, "R11 dead read 15");
        for (int p = 0; p < N; p++) begin
            rd(2 * p, 32'h8000_0000, "R11 ctrl untouched");
            rd(2 * p + 1, 32'h0, "R11 data untouched");
        end

        // R3: every direction-bit combination on every port
        for (int p = 0; p < N; p++) begin
            for (int m = 0; m < 16; m++) begin
                wr(2 * p, (32'(m & 1) << 4) | (32'((m >> 1) & 1) << 12) |
                          (32'((m >> 2) & 1) << 20) | (32'((m >> 3) & 1) << 28));
                chk("R3 tclk oe", 32'(tclk_oe), 32'(m & 1) << p);
                chk("R3 tfs oe", 32'(tfs_oe), 32'((m >> 1) & 1) << p);
                chk("R3 rclk oe", 32'(rclk_oe), 32'((m >> 2) & 1) << p);
                chk("R3 rfs oe", 32'(rfs_oe), 32'((m >> 3) & 1) << p);
            end
            wr(2 * p + 1, 32'h8000_0000);
        end

        // R4: separate clocks, every source and side, several pad patterns
        for (int p = 0; p < N; p++) begin
            for (int s = 0; s <= N; s++) begin
                for (int fr = 0; fr < 2; fr++) begin
                    logic [31:0] f;
                    f = sel(s, fr[0], 1'b1);
                    wr(2 * p, f | (f << 8) | (f << 16) | (f << 24));
                    for (int k = 0; k < 3; k++) begin
                        tclk_in = pat(k, 1); tfs_in = pat(k, 2);
                        rclk_in = pat(k, 3); rfs_in = pat(k, 4);
                        #1;
                        chk("R4 tclk route", 32'(tclk_out[p]), 32'(pick(s, fr[0], tclk_in, rclk_in)));
                        chk("R4 tfs route", 32'(tfs_out[p]), 32'(pick(s, fr[0], tfs_in, rfs_in)));
                        chk("R4 rclk route", 32'(rclk_out[p]), 32'(pick(s, fr[0], tclk_in, rclk_in)));
                        chk("R4 rfs route", 32'(rfs_out[p]), 32'(pick(s, fr[0], tfs_in, rfs_in)));
                    end
                end
            end
            wr(2 * p + 1, 32'h8000_0000);
        end

        // R5: shared-clock mode makes the receive pair follow transmit selectors
        for (int s1 = 0; s1 < N; s1++) begin
            for (int s2 = 0; s2 < N; s2++) begin
                wr(2, sel(s1, 1'b0, 1'b1) | (sel(s2, 1'b1, 1'b1) << 8) |
                      (sel(s2, 1'b1, 1'b1) << 16) | (sel(s1, 1'b0, 1'b1) << 24) | 32'h8000_0000);
                for (int k = 0; k < 2; k++) begin
                    tclk_in = pat(k, 5); tfs_in = pat(k, 6);
                    rclk_in = pat(k, 7); rfs_in = pat(k, 8);
                    #1;
                    chk("R5 shared rclk", 32'(rclk_out[1]), 32'(tclk_in[s1]));
                    chk("R5 shared rfs", 32'(rfs_out[1]), 32'(rfs_in[s2]));
                    chk("R5 rclk enable kept", 32'(rclk_oe[1]), 32'h1);
                end
            end
        end
        clear_all();

        // R6: direct source in normal and reserved mode, and empty source
        for (int p = 0; p < N; p++) begin
            for (int s = 0; s <= N; s++) begin
                for (int md = 0; md < 4; md += 3) begin
                    wr(2 * p + 1, mk_data(s, md, 1'b0, 0));
                    for (int k = 0; k < 2; k++) begin
                        pin_a_in = pat(k, 9 + s);
                        #1;
                        chk("R6 direct rxd", 32'(pin_b_out[p]),
                            (s >= N) ? 32'h1 : 32'(pin_a_in[s]));
                    end
                end
            end
            wr(2 * p + 1, 32'h8000_0000);
        end

        // R7: masked AND over every mask value
        for (int pi = 0; pi < 2; pi++) begin
            int p;
            p = pi * 4;
            for (int m = 0; m < 128; m++) begin
                wr(2 * p + 1, mk_data(0, 1, 1'b0, m));
                for (int k = 0; k < 3; k++) begin
                    pin_a_in = (k == 0) ? 7'h7F : pat(k + m, 3);
                    #1;
                    chk("R7 masked and", 32'(pin_b_out[p]),
                        32'(&(pin_a_in | 7'(m))));
                end
            end
            wr(2 * p + 1, 32'h8000_0000);
        end

        // R8: bus network AND for every membership set
        for (int set = 0; set < 128; set++) begin
            for (int p = 0; p < N; p++)
                wr(2 * p + 1, mk_data(0, set[p] ? 2 : 0, 1'b0, 0));
            for (int k = 0; k < 2; k++) begin
                pin_a_in = (k == 0) ? 7'h7F : pat(set, 4);
                #1;
                for (int p = 0; p < N; p++) begin
                    if (set[p])
                        chk("R8 bus and", 32'(pin_b_out[p]),
                            32'(&(pin_a_in | ~7'(set) | (7'h1 << p))));
                end
            end
        end
        clear_all();

        // R9: swap moves both the transmit pick-up and the receive drive
        wr(5, mk_data(5, 0, 1'b1, 0));
        wr(11, mk_data(2, 0, 1'b0, 0));
        chk("R9 swapped enables", {30'h0, pin_a_oe[2], pin_b_oe[2]}, 32'h2);
        chk("R9 plain enables", {30'h0, pin_a_oe[5], pin_b_oe[5]}, 32'h1);
        for (int k = 0; k < 4; k++) begin
            pin_a_in = pat(k, 10);
            pin_b_in = ~pat(k, 10);
            #1;
            chk("R9 tx from pin b", 32'(pin_b_out[5]), 32'(pin_b_in[2]));
            chk("R9 rx on pin a", 32'(pin_a_out[2]), 32'(pin_a_in[5]));
        end

        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

endmodule